// File: doc/BRIEF.md
# Table-Driven Multi-Way Branch Resolver

This unit resolves a multi-way branch from a table held in byte-addressed memory. A start command brings in a 24-bit table base, a selector, a limit and a mode bit. The unit then reads the table through a byte read port and reports whether the branch is taken and, if it is, the 24-bit jump target. Loading the program counter and decoding the instruction are handled by the surrounding core.

The mode bit chooses between two table layouts. In indexed mode the table is a packed list of 3-byte addresses. The selector picks one entry directly, after a bounds check against the limit. In search mode the table is a list of 4-byte records, each made of a key byte followed by a 3-byte address. The unit compares each key with the selector and stops at the first match. It examines no more than the limit number of records.

Each result ends with a one-cycle done pulse. The taken flag and the target stay valid until the next accepted start.

Top module: `case_dispatch`

## Requirements
- R1: In indexed mode (search_mode = 0) with selector < limit, the unit reads exactly three bytes at tbl_base + 3*selector, +1 and +2. The target is assembled with the first byte as bits 7:0, the second as bits 15:8 and the third as bits 23:16, and taken is 1.
- R2: In indexed mode with selector >= limit, the unit issues no read, taken is 0 and target is 0 at done.
- R3: In search mode (search_mode = 1), record i starts at tbl_base + 4*i. Its key byte comes first and its address follows, low byte first, at offsets 1 to 3. The target is the address of the lowest-numbered record whose key equals the selector, and taken is 1.
- R4: In search mode, records with index >= limit are never read. If no record with index below the limit matches, exactly limit key reads are made, taken is 0 and target is 0.
- R5: A limit of zero gives taken = 0 and target = 0 with no read, in either mode.
- R6: done is high for exactly one cycle per accepted start. taken and target keep their values from done until the next accepted start.
- R7: A start raised while an operation is in progress is ignored and does not change the result of that operation.
- R8: Every read is a single-cycle rd_req. The unit waits for rd_valid, after any latency of one cycle or more, before it issues the next read, and it never issues a read while idle.
- R9: After reset, done, taken and rd_req are 0 and target is 0.
- R10: All table address arithmetic wraps modulo 2^24.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a resolution; sampled only while idle |
| search_mode | input | 1 | 0 = indexed table, 1 = key/address record search |
| tbl_base | input | 24 | Byte address of the table |
| selector | input | 8 | Entry index (indexed) or key to match (search) |
| limit | input | 8 | Entry bound (indexed) or maximum record count (search) |
| rd_req | output | 1 | One-cycle read request |
| rd_addr | output | 24 | Byte address of the read |
| rd_valid | input | 1 | Read data is present on rd_data |
| rd_data | input | 8 | Returned byte |
| done | output | 1 | One-cycle completion pulse |
| taken | output | 1 | Branch taken (held until the next start) |
| target | output | 24 | Jump target, 0 on fall-through (held) |

## Verification
The bench targets the edges of the bounds check: selector equal to limit - 1 and equal to limit, a selector well beyond the limit, and limit zero in both modes. A design with an off-by-one bound would either read one entry past the table or refuse the last valid entry, and the per-operation read count catches both. In search mode the bench covers a matching key placed just beyond the record limit, duplicate keys (only the first may win) and a table base near the top of the address space. These expose a walker that overruns its limit, returns the last match instead of the first, or carries address arithmetic into a 25th bit. A second start fired mid-operation, and slow read responses, check that the in-flight result is neither restarted nor corrupted.

// File: rtl/case_dispatch_pkg.sv
package case_dispatch_pkg;

   typedef enum logic [2:0] {
      CD_IDLE,
      CD_EVAL,
      CD_KEY_REQ,
      CD_KEY_WAIT,
      CD_ADR_REQ,
      CD_ADR_WAIT,
      CD_DONE
   } cd_state_e;

   function automatic int cd_max(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/case_dispatch_offset.sv
// Scales the selector by the entry stride (selector * STRIDE), modulo 2^ADDR_W.
module case_dispatch_offset #(
   parameter int ADDR_W   = 24,
   parameter int SEL_W    = 8,
   parameter int STRIDE   = 3,
   parameter bit USE_MULT = 1'b0
) (
   input  logic [SEL_W-1:0]  sel,
   output logic [ADDR_W-1:0] offs
);

   localparam int TERMS = $clog2(STRIDE + 1);
   localparam logic [31:0] STRIDE_V = 32'(STRIDE);

   logic [ADDR_W-1:0] sel_ext;
   assign sel_ext = ADDR_W'(sel);

   generate
      if (USE_MULT) begin : g_mult
         assign offs = sel_ext * ADDR_W'(STRIDE);
      end else begin : g_shift_add
         // Constant stride: one shifted copy of the selector per set bit.
         logic [ADDR_W-1:0] part [TERMS];
         for (genvar i = 0; i < TERMS; i++) begin : g_term
            if (STRIDE_V[i]) begin : g_on
               assign part[i] = sel_ext << i;
            end else begin : g_off
               assign part[i] = '0;
            end
         end
         always_comb begin
            offs = '0;
            for (int k = 0; k < TERMS; k++) begin
               offs = offs + part[k];
            end
         end
      end
   endgenerate

endmodule

// File: rtl/case_dispatch_collect.sv
// Gathers the address bytes into one word, one byte lane per read, lowest address in the least significant lane.
module case_dispatch_collect #(
   parameter int ADDR_W = 24,
   parameter int NBYTES = 3,
   parameter int IDX_W  = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clear,
   input  logic              load,
   input  logic [IDX_W-1:0]  idx,
   input  logic [7:0]        byte_in,
   output logic [ADDR_W-1:0] word
);

   generate
      for (genvar g = 0; g < NBYTES; g++) begin : g_lane
         logic [7:0] lane_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               lane_q <= '0;
            end else if (clear) begin
               lane_q <= '0;
            end else if (load && (idx == IDX_W'(g))) begin
               lane_q <= byte_in;
            end
         end
         assign word[g*8 +: 8] = lane_q;
      end
   endgenerate

endmodule

// File: rtl/case_dispatch_ctrl.sv
// Sequencer: bounds check, record walk and address fetch.
module case_dispatch_ctrl
   import case_dispatch_pkg::*;
#(
   parameter int ADDR_W = 24,
   parameter int SEL_W  = 8,
   parameter int LIM_W  = 8,
   parameter int NBYTES = 3,
   parameter int IDX_W  = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              search_mode,
   input  logic [ADDR_W-1:0] tbl_base,
   input  logic [SEL_W-1:0]  selector,
   input  logic [LIM_W-1:0]  limit,
   input  logic [ADDR_W-1:0] idx_offs,
   input  logic              rd_valid,
   input  logic [7:0]        rd_data,
   output logic [SEL_W-1:0]  sel_q,
   output logic              rd_req,
   output logic [ADDR_W-1:0] rd_addr,
   output logic              busy,
   output logic              done,
   output logic              taken,
   output logic              col_clear,
   output logic              col_load,
   output logic [IDX_W-1:0]  col_idx
);

   localparam int REC_BYTES = NBYTES + 1;
   localparam int CMP_W     = cd_max(SEL_W, LIM_W);
   localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NBYTES - 1);

   cd_state_e         state;
   logic              mode_q;
   logic [ADDR_W-1:0] base_q;
   logic [LIM_W-1:0]  lim_q;
   logic [ADDR_W-1:0] rec_ptr;
   logic [LIM_W-1:0]  rec_cnt;
   logic [ADDR_W-1:0] fetch_ptr;
   logic [IDX_W-1:0]  nbyte;
   logic              taken_q;
   logic              out_of_range;
   logic              walk_over;
   logic              key_hit;

   assign out_of_range = CMP_W'(sel_q) >= CMP_W'(lim_q);
   assign walk_over    = (rec_cnt == lim_q);
   assign key_hit      = (rd_data == 8'(sel_q));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= CD_IDLE;
         mode_q    <= 1'b0;
         base_q    <= '0;
         sel_q     <= '0;
         lim_q     <= '0;
         rec_ptr   <= '0;
         rec_cnt   <= '0;
         fetch_ptr <= '0;
         nbyte     <= '0;
         taken_q   <= 1'b0;
      end else begin
         unique case (state)
            CD_IDLE: begin
               if (start) begin
                  mode_q  <= search_mode;
                  base_q  <= tbl_base;
                  sel_q   <= selector;
                  lim_q   <= limit;
                  rec_ptr <= tbl_base;
                  rec_cnt <= '0;
                  taken_q <= 1'b0;
                  state   <= CD_EVAL;
               end
            end
            CD_EVAL: begin
               if (!mode_q) begin
                  if (out_of_range) begin
                     state <= CD_DONE;
                  end else begin
                     fetch_ptr <= base_q + idx_offs;
                     nbyte     <= '0;
                     state     <= CD_ADR_REQ;
                  end
               end else if (walk_over) begin
                  state <= CD_DONE;
               end else begin
                  state <= CD_KEY_REQ;
               end
            end
            CD_KEY_REQ: state <= CD_KEY_WAIT;
            CD_KEY_WAIT: begin
               if (rd_valid) begin
                  if (key_hit) begin
                     fetch_ptr <= rec_ptr + ADDR_W'(1);
                     nbyte     <= '0;
                     state     <= CD_ADR_REQ;
                  end else begin
                     rec_ptr <= rec_ptr + ADDR_W'(REC_BYTES);
                     rec_cnt <= rec_cnt + LIM_W'(1);
                     state   <= CD_EVAL;
                  end
               end
            end
            CD_ADR_REQ: state <= CD_ADR_WAIT;
            CD_ADR_WAIT: begin
               if (rd_valid) begin
                  if (nbyte == LAST_IDX) begin
                     taken_q <= 1'b1;
                     state   <= CD_DONE;
                  end else begin
                     nbyte <= nbyte + IDX_W'(1);
                     state <= CD_ADR_REQ;
                  end
               end
            end
            CD_DONE: state <= CD_IDLE;
            default: state <= CD_IDLE;
         endcase
      end
   end

   assign rd_req    = (state == CD_KEY_REQ) || (state == CD_ADR_REQ);
   assign rd_addr   = (state == CD_KEY_REQ) ? rec_ptr : (fetch_ptr + ADDR_W'(nbyte));
   assign busy      = (state != CD_IDLE);
   assign done      = (state == CD_DONE);
   assign taken     = taken_q;
   assign col_clear = (state == CD_IDLE) && start;
   assign col_load  = (state == CD_ADR_WAIT) && rd_valid;
   assign col_idx   = nbyte;

endmodule

// File: rtl/case_dispatch.sv
module case_dispatch #(
   parameter int ADDR_W   = 24,
   parameter int SEL_W    = 8,
   parameter int LIM_W    = 8,
   parameter bit USE_MULT = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              search_mode,
   input  logic [ADDR_W-1:0] tbl_base,
   input  logic [SEL_W-1:0]  selector,
   input  logic [LIM_W-1:0]  limit,
   output logic              rd_req,
   output logic [ADDR_W-1:0] rd_addr,
   input  logic              rd_valid,
   input  logic [7:0]        rd_data,
   output logic              done,
   output logic              taken,
   output logic [ADDR_W-1:0] target
);

   localparam int NBYTES = ADDR_W / 8;
   localparam int IDX_W  = (NBYTES > 1) ? $clog2(NBYTES) : 1;

   initial begin
      assert (ADDR_W % 8 == 0 && NBYTES >= 2)
         else $fatal(1, "case_dispatch: ADDR_W must be a multiple of 8, at least 16");
      assert (SEL_W >= 1 && SEL_W <= 8)
         else $fatal(1, "case_dispatch: SEL_W must fit in one key byte");
      assert (LIM_W >= 1 && LIM_W <= 16)
         else $fatal(1, "case_dispatch: LIM_W out of range");
   end

   logic [SEL_W-1:0]  sel_q;
   logic [ADDR_W-1:0] idx_offs;
   logic              busy;
   logic              col_clear;
   logic              col_load;
   logic [IDX_W-1:0]  col_idx;

   case_dispatch_offset #(
      .ADDR_W(ADDR_W), .SEL_W(SEL_W), .STRIDE(NBYTES), .USE_MULT(USE_MULT)
   ) u_offs (
      .sel (sel_q),
      .offs(idx_offs)
   );

   case_dispatch_ctrl #(
      .ADDR_W(ADDR_W), .SEL_W(SEL_W), .LIM_W(LIM_W), .NBYTES(NBYTES), .IDX_W(IDX_W)
   ) u_ctrl (
      .clk        (clk),
      .rst_n      (rst_n),
      .start      (start),
      .search_mode(search_mode),
      .tbl_base   (tbl_base),
      .selector   (selector),
      .limit      (limit),
      .idx_offs   (idx_offs),
      .rd_valid   (rd_valid),
      .rd_data    (rd_data),
      .sel_q      (sel_q),
      .rd_req     (rd_req),
      .rd_addr    (rd_addr),
      .busy       (busy),
      .done       (done),
      .taken      (taken),
      .col_clear  (col_clear),
      .col_load   (col_load),
      .col_idx    (col_idx)
   );

   case_dispatch_collect #(
      .ADDR_W(ADDR_W), .NBYTES(NBYTES), .IDX_W(IDX_W)
   ) u_col (
      .clk    (clk),
      .rst_n  (rst_n),
      .clear  (col_clear),
      .load   (col_load),
      .idx    (col_idx),
      .byte_in(rd_data),
      .word   (target)
   );

endmodule

// File: rtl/case_dispatch_checks.sv
module case_dispatch_checks #(
   parameter int ADDR_W = 24,
   parameter int SEL_W  = 8,
   parameter int LIM_W  = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              start,
   input logic              search_mode,
   input logic [SEL_W-1:0]  selector,
   input logic [LIM_W-1:0]  limit,
   input logic              busy,
   input logic              done,
   input logic              rd_req,
   input logic              taken,
   input logic [ADDR_W-1:0] target
);

   localparam int CMP_W = (SEL_W > LIM_W) ? SEL_W : LIM_W;

   logic skip_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         skip_q <= 1'b0;
      end else if (start && !busy) begin
         skip_q <= (limit == '0) ||
                   (!search_mode && (CMP_W'(selector) >= CMP_W'(limit)));
      end
   end

   // R6: completion pulse lasts one cycle
   p_done_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R6: results hold while idle with no start
   p_hold_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && !start) |=> ($stable(taken) && $stable(target)));

   // R8: single-cycle requests, none while idle
   p_single_req_r8: assert property (@(posedge clk) disable iff (!rst_n)
      rd_req |=> !rd_req);
   p_no_idle_req_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !rd_req);

   // R2 / R5: out-of-range or zero-limit operations do not touch memory
   p_skip_no_read_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && skip_q) |-> !rd_req);
   p_skip_result_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (done && skip_q) |-> (!taken && target == '0));

   // R7: an accepted start always leads to a busy unit
   p_accept_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !busy) |=> busy);

endmodule

bind case_dispatch case_dispatch_checks #(
   .ADDR_W(ADDR_W), .SEL_W(SEL_W), .LIM_W(LIM_W)
) u_checks (
   .clk        (clk),
   .rst_n      (rst_n),
   .start      (start),
   .search_mode(search_mode),
   .selector   (selector),
   .limit      (limit),
   .busy       (busy),
   .done       (done),
   .rd_req     (rd_req),
   .taken      (taken),
   .target     (target)
);

// File: tb/case_dispatch_test.sv
`timescale 1ns/1ps
module case_dispatch_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic        search_mode = 1'b0;
   logic [23:0] tbl_base = '0;
   logic [7:0]  selector = '0;
   logic [7:0]  limit = '0;
   logic        rd_req;
   logic [23:0] rd_addr;
   logic        rd_valid;
   logic [7:0]  rd_data;
   logic        done;
   logic        taken;
   logic [23:0] target;

   always #2.5 clk = ~clk;

   case_dispatch uut (
      .clk(clk), .rst_n(rst_n), .start(start), .search_mode(search_mode),
      .tbl_base(tbl_base), .selector(selector), .limit(limit),
      .rd_req(rd_req), .rd_addr(rd_addr), .rd_valid(rd_valid), .rd_data(rd_data),
      .done(done), .taken(taken), .target(target)
   );

   // Memory model: 4 KiB image aliased over the 24-bit space
   logic [7:0]  mem [0:4095];
   int          lat_cfg = 1;
   int          wait_left;
   logic [23:0] pend_addr;

   always @(posedge clk) begin
      if (!rst_n) begin
         rd_valid  <= 1'b0;
         rd_data   <= '0;
         wait_left <= 0;
         pend_addr <= '0;
      end else begin
         rd_valid <= 1'b0;
         if (rd_req) begin
            pend_addr <= rd_addr;
            wait_left <= lat_cfg;
         end else if (wait_left != 0) begin
            wait_left <= wait_left - 1;
            if (wait_left == 1) begin
               rd_valid <= 1'b1;
               rd_data  <= mem[pend_addr[11:0]];
            end
         end
      end
   end

   function automatic logic [7:0] mb(input logic [23:0] a);
      return mem[a[11:0]];
   endfunction

   int checks = 0;
   int errors = 0;

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // Scoreboard
   logic        exp_tk_q [$];
   logic [23:0] exp_tg_q [$];
   int          exp_rd_q [$];
   string       exp_tag_q [$];
   int          reads_seen = 0;
   int          n_done = 0;
   logic        prev_done = 1'b0;

   always @(negedge clk) begin
      if (rst_n) begin
         if (rd_req) reads_seen++;
         if (done && prev_done) begin
            checks++; errors++;
            $display("FAIL R6 done width actual=2+ expected=1");
         end
         if (done && !prev_done) begin
            if (exp_tk_q.size() == 0) begin
               checks++; errors++;
               $display("FAIL R6 unexpected done actual=1 expected=0");
            end else begin
               string t;
               t = exp_tag_q.pop_front();
               chk({t, " taken"},  32'(taken),  32'(exp_tk_q.pop_front()));
               chk({t, " target"}, 32'(target), 32'(exp_tg_q.pop_front()));
               chk({t, " reads"},  32'(reads_seen), 32'(exp_rd_q.pop_front()));
            end
            reads_seen = 0;
            n_done++;
         end
         prev_done = done;
      end
   end

   task automatic run(input logic m, input logic [23:0] b, input logic [7:0] s,
                      input logic [7:0] l, input string tag, input bit noise);
      logic        tk = 1'b0;
      logic [23:0] tg = '0;
      int          nr = 0;
      int          goal;
      if (!m) begin
         if (s < l) begin
            logic [23:0] a;
            a  = b + 24'(s) * 24'd3;
            tg = {mb(a + 24'd2), mb(a + 24'd1), mb(a)};
            tk = 1'b1;
            nr = 3;
         end
      end else begin
         for (int i = 0; i < int'(l); i++) begin
            logic [23:0] a;
            a = b + 24'(i) * 24'd4;
            nr++;
            if (mb(a) == s) begin
               tg = {mb(a + 24'd3), mb(a + 24'd2), mb(a + 24'd1)};
               tk = 1'b1;
               nr += 3;
               break;
            end
         end
      end
      exp_tk_q.push_back(tk);
      exp_tg_q.push_back(tg);
      exp_rd_q.push_back(nr);
      exp_tag_q.push_back(tag);
      goal = n_done + 1;
      @(negedge clk);
      search_mode = m; tbl_base = b; selector = s; limit = l; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      if (noise) begin
         repeat (2) @(negedge clk);
         search_mode = ~m; tbl_base = b + 24'h40; selector = s + 8'd1; limit = 8'hFF;
         start = 1'b1;
         @(negedge clk);
         start = 1'b0;
      end
      wait (n_done >= goal);
      @(negedge clk);
   endtask

   initial begin
      #(5.0 * 150000);
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      logic        hold_tk;
      logic [23:0] hold_tg;
      for (int i = 0; i < 4096; i++) mem[i] = 8'(i * 37 + 11);
      // search records at 0x200: keys 05, 09, 11, 09, 33
      mem[12'h200] = 8'h05; mem[12'h204] = 8'h09; mem[12'h208] = 8'h11;
      mem[12'h20C] = 8'h09; mem[12'h210] = 8'h33;
      // wrapping search table at 0xFFFFFA
      mem[12'hFFA] = 8'h01; mem[12'hFFE] = 8'h42;

      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R9 done",   32'(done),   0);
      chk("R9 taken",  32'(taken),  0);
      chk("R9 target", 32'(target), 0);
      chk("R9 rd_req", 32'(rd_req), 0);

      run(1'b0, 24'h000100, 8'd0,   8'd4, "R1 idx sel0", 1'b0);
      run(1'b0, 24'h000100, 8'd2,   8'd4, "R1 idx sel2", 1'b0);
      run(1'b0, 24'h000100, 8'd3,   8'd4, "R1 idx last in range", 1'b0);
      run(1'b0, 24'h000100, 8'd4,   8'd4, "R2 idx sel==limit", 1'b0);
      run(1'b0, 24'h000100, 8'd200, 8'd4, "R2 idx sel>limit", 1'b0);
      run(1'b0, 24'h000100, 8'd0,   8'd0, "R5 idx limit0", 1'b0);
      run(1'b1, 24'h000200, 8'h05,  8'd0, "R5 search limit0", 1'b0);
      run(1'b1, 24'h000200, 8'h05,  8'd5, "R3 search first rec", 1'b0);
      run(1'b1, 24'h000200, 8'h11,  8'd5, "R3 search third rec", 1'b0);
      run(1'b1, 24'h000200, 8'h09,  8'd5, "R3 search dup key first wins", 1'b0);
      run(1'b1, 24'h000200, 8'h33,  8'd4, "R4 search match beyond limit", 1'b0);
      run(1'b1, 24'h000200, 8'h77,  8'd4, "R4 search no match", 1'b0);
      run(1'b0, 24'hFFFFFE, 8'd0,   8'd1, "R10 idx wrap", 1'b0);
      run(1'b1, 24'hFFFFFA, 8'h42,  8'd2, "R10 search wrap", 1'b0);
      lat_cfg = 3;
      run(1'b1, 24'h000200, 8'h11,  8'd5, "R8 slow read search", 1'b0);
      run(1'b0, 24'h000100, 8'd1,   8'd4, "R8 slow read idx", 1'b0);
      lat_cfg = 1;
      run(1'b0, 24'h000100, 8'd1,   8'd4, "R7 start while busy", 1'b1);

      // R6: results held while idle
      hold_tk = taken;
      hold_tg = target;
      repeat (6) @(negedge clk);
      chk("R6 hold taken",  32'(taken),  32'(hold_tk));
      chk("R6 hold target", 32'(target), 32'(hold_tg));
      chk("R6 no extra done", 32'(exp_tk_q.size()), 0);

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule